// File: doc/BRIEF.md
# Instruction Fetch Execution Guard

This block sits on the instruction and data path between a 32-bit processor core and its memory system. For every access it compares the address with the protected regions in the same cycle the access is presented. When an instruction fetch falls inside a protected region, the word returned to the core is replaced with an all-zero word, which the core decodes as illegal and traps on. Data loads and stores are never altered.

Two regions are protected. The first is the firmware-private RAM, which is always protected. It is 2 KiB starting at the base of the space whose top address byte is 0xd0. The second is a single no-execute window that software defines through three write-only configuration registers. Once software arms the window, the arm bit cannot be cleared and the window bounds cannot be changed until the next reset.

Top module: `fetch_guard`

## Requirements
- R1: After reset the window is disarmed with both bounds at zero. A fetch outside the firmware RAM returns mem_rdata unchanged, with fetch_blocked low.
- R2: A fetch whose top address byte is 0xd0 and whose low 24 bits are below 0x800 is always blocked, whatever the configuration registers hold.
- R3: A fetch at 0xd000_0800 is just past the end of the firmware RAM and is not blocked by that region.
- R4: Once armed, a fetch whose address lies between the first-bound and last-bound registers, both bounds included, is blocked.
- R5: A fetch below the first bound or above the last bound is not blocked by the window. When the window is disarmed, the window blocks nothing.
- R6: A write with cfg_sel = 0 (control) and bit 0 of cfg_wdata set arms the window. A control write with bit 0 clear does not arm it. cfg_sel = 1 selects the first bound and cfg_sel = 2 selects the last bound.
- R7: Once armed, the window stays armed until reset. A later control write with bit 0 clear has no effect.
- R8: Once armed, writes to the first-bound and last-bound registers are ignored.
- R9: A data access (bus_is_fetch = 0) always returns mem_rdata unchanged, with fetch_blocked low, even inside a protected region.
- R10: The protection decision is combinational in the cycle the fetch is presented, so a blocked word never reaches core_rdata.
- R11: A blocked fetch returns 32'h0000_0000 on core_rdata and raises fetch_blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 first bound, 2 last bound |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_is_fetch | input | 1 | The access is an instruction fetch |
| bus_addr | input | 32 | Access address |
| mem_rdata | input | 32 | Word returned by memory |
| core_rdata | output | 32 | Word delivered to the core |
| fetch_blocked | output | 1 | The current fetch hits a protected region |

## Verification
On every cycle the assertions check four things: firmware RAM fetches always come back as the illegal word, data accesses are never altered, any blocked access returns the zero word, and an armed window keeps both its arm bit and its bounds. The bench's scenarios are needed for the rest. They cover the inclusive edges of the window, the first word past the firmware RAM, a control write that leaves the window disarmed, and bound rewrites after arming that must leave blocking unchanged. A random phase then sets the output against a reference model over fetches and data accesses clustered around both regions.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    CFG_CTRL  = 2'd0,
    CFG_FIRST = 2'd1,
    CFG_LAST  = 2'd2
  } cfg_sel_e;

  localparam logic [31:0] ILLEGAL_WORD = 32'h0000_0000;
endpackage

// File: rtl/fg_regs.sv
module fg_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic          win_en,
  output logic [AW-1:0] win_first,
  output logic [AW-1:0] win_last
);
  import fg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en    <= 1'b0;
      win_first <= '0;
      win_last  <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        CFG_CTRL:  if (wdata[0]) win_en <= 1'b1;
        CFG_FIRST: if (!win_en) win_first <= wdata;
        CFG_LAST:  if (!win_en) win_last <= wdata;
        default: ;
      endcase
    end
  end

  AST_ARM_ON_BIT0: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd0 && wdata[0]) |=> win_en); // R6
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(win_en) |-> win_en); // R7
  AST_BOUNDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(win_en) |-> ($stable(win_first) && $stable(win_last))); // R8
endmodule

// File: rtl/fg_range_hit.sv
module fg_range_hit #(
  parameter int AW = 32
) (
  input  logic          active,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  always_comb hit = active && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/fg_fetch_mux.sv
module fg_fetch_mux #(
  parameter int DW = 32
) (
  input  logic          block,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] core_rdata
);
  import fg_pkg::*;
  always_comb core_rdata = block ? DW'(ILLEGAL_WORD) : mem_rdata;
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter int          PREFIX_W    = 8,
  parameter logic [7:0]  FW_PREFIX   = 8'hd0,
  parameter int          FW_BYTES    = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          bus_valid,
  input  logic          bus_is_fetch,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] core_rdata,
  output logic          fetch_blocked
);
  localparam int          NREG  = 2;
  localparam logic [AW-1:0] FW_LO = {FW_PREFIX[PREFIX_W-1:0], {(AW-PREFIX_W){1'b0}}};
  localparam logic [AW-1:0] FW_HI = FW_LO + AW'(FW_BYTES - 1);

  logic          win_en;
  logic [AW-1:0] win_first, win_last;
  logic          is_fetch;
  logic [AW-1:0] lo_arr [NREG];
  logic [AW-1:0] hi_arr [NREG];
  logic          act_arr [NREG];
  logic [NREG-1:0] hit;

  fg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .win_en(win_en), .win_first(win_first), .win_last(win_last)
  );

  always_comb begin
    lo_arr[0]  = FW_LO;
    hi_arr[0]  = FW_HI;
    act_arr[0] = 1'b1;
    lo_arr[1]  = win_first;
    hi_arr[1]  = win_last;
    act_arr[1] = win_en;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_region
    fg_range_hit #(.AW(AW)) u_hit (
      .active(act_arr[g]), .addr(bus_addr),
      .lo(lo_arr[g]), .hi(hi_arr[g]), .hit(hit[g])
    );
  end

  always_comb is_fetch = bus_valid && bus_is_fetch;
  always_comb fetch_blocked = is_fetch && (|hit);

  fg_fetch_mux #(.DW(DW)) u_mux (
    .block(fetch_blocked), .mem_rdata(mem_rdata), .core_rdata(core_rdata)
  );

  AST_FWRAM_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_is_fetch && bus_addr >= FW_LO && bus_addr <= FW_HI)
      |-> (fetch_blocked && core_rdata == '0)); // R2
  AST_DATA_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_is_fetch) |-> (!fetch_blocked && core_rdata == mem_rdata)); // R9
  AST_BLOCK_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    fetch_blocked |-> (core_rdata == '0)); // R11
endmodule

// File: tb/fetch_guard_bench.sv
module fetch_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic        bus_is_fetch = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] core_rdata;
  logic        fetch_blocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_en = 0;
  logic [31:0] m_first = '0;
  logic [31:0] m_last = '0;

  always #5 clk = ~clk;

  fetch_guard u_fetch_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_is_fetch(bus_is_fetch), .bus_addr(bus_addr),
    .mem_rdata(mem_rdata), .core_rdata(core_rdata), .fetch_blocked(fetch_blocked)
  );

  function automatic bit exp_block(input bit v, input bit f, input logic [31:0] a);
    bit fw;
    fw = (a[31:24] == 8'hd0) && (a[23:0] < 24'h800);
    return v && f && (fw || (m_en && a >= m_first && a <= m_last));
  endfunction

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      2'd0: if (d[0]) m_en = 1;
      2'd1: if (!m_en) m_first = d;
      2'd2: if (!m_en) m_last = d;
      default: ;
    endcase
  endtask

  task automatic access(input bit v, input bit f, input logic [31:0] a, input string req);
    logic [31:0] md, er;
    bit eb;
    @(negedge clk);
    md = $urandom | 32'h1;
    bus_valid = v; bus_is_fetch = f; bus_addr = a; mem_rdata = md;
    #2;
    eb = exp_block(v, f, a);
    er = eb ? 32'h0 : md;
    checks++;
    if (core_rdata !== er || fetch_blocked !== eb) begin
      errors++;
      $display("FAIL %s addr=%h fetch=%0b: rdata=%h blocked=%0b expected rdata=%h blocked=%0b",
               req, a, f, core_rdata, fetch_blocked, er, eb);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, window disarmed
    access(1, 1, 32'h4000_1000, "R1");
    access(1, 1, 32'h0000_0000, "R1");
    // R2: firmware RAM always blocked
    access(1, 1, 32'hd000_0000, "R2");
    access(1, 1, 32'hd000_07fc, "R2");
    // R3: first word past firmware RAM
    access(1, 1, 32'hd000_0800, "R3");
    access(1, 1, 32'hcfff_fffc, "R3");
    // R6: control write with bit 0 clear does not arm
    cfg_write(2'd1, 32'h4000_1000);
    cfg_write(2'd2, 32'h4000_10fc);
    cfg_write(2'd0, 32'hffff_fffe);
    access(1, 1, 32'h4000_1000, "R6");
    access(1, 1, 32'h4000_1080, "R5");
    // R6: arm, R4 inclusive bounds
    cfg_write(2'd0, 32'h0000_0001);
    access(1, 1, 32'h4000_1000, "R4");
    access(1, 1, 32'h4000_10fc, "R4");
    access(1, 1, 32'h4000_1040, "R10");
    access(1, 1, 32'h4000_0ffc, "R5");
    access(1, 1, 32'h4000_1100, "R5");
    // R9: data access inside protected regions
    access(1, 0, 32'h4000_1040, "R9");
    access(1, 0, 32'hd000_0010, "R9");
    // R11: blocked word is zero
    access(1, 1, 32'hd000_0400, "R11");
    // R7: clearing bit 0 after arming has no effect
    cfg_write(2'd0, 32'h0000_0000);
    access(1, 1, 32'h4000_1010, "R7");
    // R8: bound rewrites after arming are ignored
    cfg_write(2'd1, 32'h0000_0000);
    cfg_write(2'd2, 32'hffff_fffc);
    access(1, 1, 32'h4000_2000, "R8");
    access(1, 1, 32'h0000_0100, "R8");
    access(1, 1, 32'h4000_1000, "R8");
    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      case ($urandom % 4)
        0: a = 32'hd000_0000 + ($urandom % 32'h1000);
        1: a = 32'h4000_0f00 + ($urandom % 32'h300);
        default: a = $urandom;
      endcase
      access(($urandom % 8) != 0, $urandom % 2, a, "R4");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule